// File: doc/BRIEF.md
# Delay-Locked-Loop Start-Up and Lock Capture Sequencer

This block brings a memory PHY's delay-locked loop out of reset by issuing a fixed series of register writes. Once it has been kicked, it writes the initial control word. It then writes a configuration word that carries the refresh count and the phase-shift code. Next it turns the loop on, and in a separate write it starts the loop. It then watches a status word until all three ready bits read one. At that point it takes the 8-bit coarse lock value from the status word, ORs it into the top byte of the control word, and writes the result. That last write pins the delay at the measured value. After it, the block raises a locked flag.

The write side is a pair of plain one-cycle strobes with data: one for the control register and one for the configuration register. There is no valid/ready handshake. The receiving register file must take every strobe in the cycle it is presented, because the block cannot be held back. The kick input and the status word are plain control and status pins. A kick that arrives while the block is idle or locked starts a fresh sequence. A kick that arrives while a sequence is running is dropped.

Top module: `dll_start_ctrl`

## Requirements
- R1: After reset, both write strobes and the locked flag are low. No write is issued until a kick is seen.
- R2: The first write after a kick is a control write of 0x00101000.
- R3: The second write is a configuration write. Its value is (refresh count << 4) | shift code: 0x85 when shift_sel_i=0 (90 degrees) and 0x86 when shift_sel_i=1 (180 degrees), with a refresh count of 8.
- R4: The third write is a control write of 0x00101002, which sets bit 1 (loop on). The fourth is a separate control write of 0x00101003, which adds bit 0 (loop start).
- R5: Every strobe is high for one cycle. At most one strobe is high at a time. Two writes are always separated by at least GAP idle cycles (GAP=1 by default).
- R6: No further write follows the start write while status bits 2:0 are not all ones. Once the sequencer is polling, the force write comes two cycles after the first cycle in which they are all ones.
- R7: The fifth and final write is a control write of 0x00101003 | (status[13:6] << 24). The status value used is the one present in the cycle the ready bits were seen.
- R8: The locked flag is low while the force write is strobed. It rises in the next cycle and then stays high, with no further writes, until a new kick.
- R9: A kick during a running sequence is ignored: it does not change the written sequence.
- R10: A kick while locked restarts the whole sequence. Locked is low by the time the first control write is strobed.
- R11: Status is ignored outside the polling step. Ready bits that are already all ones before or during the first four writes neither skip nor reorder any of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick_i | input | 1 | Starts a sequence when idle or locked |
| shift_sel_i | input | 1 | Phase-shift choice: 0 gives 90 degrees, 1 gives 180 degrees |
| lock_stat_i | input | 16 | Status word: bits 2:0 are ready, bits 13:6 are the coarse lock value |
| ctl_wr_o | output | 1 | Control-register write strobe |
| ctl_data_o | output | 32 | Control-register write data |
| cfg_wr_o | output | 1 | Configuration-register write strobe |
| cfg_data_o | output | 32 | Configuration-register write data |
| locked_o | output | 1 | High once the force write has been issued |

## Verification
The bench runs the full sequence for both phase-shift choices and for all 256 coarse lock values. Because the top byte of the force write must equal the lock value, a swapped, shifted or wrong field shows up in the data. Before the ready bits become all ones, the status word carries each partial ready pattern together with the complement of the lock value. This separates a poll that is too loose, or a capture taken on the wrong cycle, from a correct one. Some runs present all-ones ready bits from before the kick, to show that early status skips nothing. Others pulse the kick in mid-sequence or start again from the locked state, which separates an ignored kick from a restart.

// File: rtl/dll_start_pkg.sv
package dll_start_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_INIT  = 3'd1,
    S_CFG   = 3'd2,
    S_ON    = 3'd3,
    S_GO    = 3'd4,
    S_POLL  = 3'd5,
    S_FORCE = 3'd6,
    S_DONE  = 3'd7
  } dll_seq_e;

  localparam int LOOP_ON_BIT   = 1;
  localparam int LOOP_GO_BIT   = 0;
  localparam int SHIFT90_CODE  = 5;
  localparam int SHIFT180_CODE = 6;

  function automatic logic [7:0] make_cfg(input int unsigned refcnt, input logic sel180);
    int unsigned code;
    code = sel180 ? SHIFT180_CODE : SHIFT90_CODE;
    return 8'((refcnt << 4) | code);
  endfunction

endpackage

// File: rtl/dll_gap_timer.sv
module dll_gap_timer #(
  parameter int GAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = (GAP < 2) ? 1 : $clog2(GAP + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= CW'(GAP);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R5: a new write is only launched once the previous spacing has run out
  p_load_when_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o);

endmodule

// File: rtl/dll_lock_merge.sv
module dll_lock_merge #(
  parameter int DW        = 32,
  parameter int SW        = 16,
  parameter int RDY_W     = 3,
  parameter int LOCK_LSB  = 6,
  parameter int LOCK_W    = 8,
  parameter int FORCE_LSB = 24
) (
  input  logic [SW-1:0]     stat_i,
  input  logic [DW-1:0]     base_i,
  input  logic [LOCK_W-1:0] lock_i,
  output logic              ready_o,
  output logic [LOCK_W-1:0] lock_o,
  output logic [DW-1:0]     merged_o
);
  localparam logic [SW-1:0] RDY_MASK = SW'((1 << RDY_W) - 1);
  localparam logic [SW-1:0] LV_MASK  = SW'(((1 << LOCK_W) - 1) << LOCK_LSB);

  logic unused_stat;

  assign ready_o     = &stat_i[RDY_W-1:0];
  assign lock_o      = stat_i[LOCK_LSB +: LOCK_W];
  assign merged_o    = base_i | (DW'(lock_i) << FORCE_LSB);
  assign unused_stat = ^(stat_i & ~(RDY_MASK | LV_MASK));

endmodule

// File: rtl/dll_seq_fsm.sv
module dll_seq_fsm
  import dll_start_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          LOCK_W   = 8,
  parameter logic [31:0] INIT_CTL = 32'h0010_1000,
  parameter int          REFCNT   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick_i,
  input  logic              sel180_i,
  input  logic              gap_busy_i,
  input  logic              ready_i,
  input  logic [LOCK_W-1:0] lock_i,
  input  logic [DW-1:0]     merged_i,
  output logic              fire_o,
  output logic [DW-1:0]     shadow_o,
  output logic [LOCK_W-1:0] lock_q_o,
  output logic              ctl_wr_o,
  output logic [DW-1:0]     ctl_data_o,
  output logic              cfg_wr_o,
  output logic [DW-1:0]     cfg_data_o,
  output logic              locked_o
);
  localparam logic [DW-1:0] ON_MASK = DW'(1) << LOOP_ON_BIT;
  localparam logic [DW-1:0] GO_MASK = DW'(1) << LOOP_GO_BIT;

  dll_seq_e        state_q;
  logic [DW-1:0]   shadow_q;
  logic [DW-1:0]   next_ctl;
  logic            write_step;

  always_comb begin
    write_step = (state_q == S_INIT) || (state_q == S_CFG) || (state_q == S_ON) ||
                 (state_q == S_GO)   || (state_q == S_FORCE);
    unique case (state_q)
      S_INIT:  next_ctl = DW'(INIT_CTL);
      S_ON:    next_ctl = shadow_q | ON_MASK;
      S_GO:    next_ctl = shadow_q | GO_MASK;
      S_FORCE: next_ctl = merged_i;
      default: next_ctl = shadow_q;
    endcase
  end

  assign fire_o   = write_step && !gap_busy_i;
  assign shadow_o = shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      shadow_q   <= '0;
      lock_q_o   <= '0;
      ctl_wr_o   <= 1'b0;
      ctl_data_o <= '0;
      cfg_wr_o   <= 1'b0;
      cfg_data_o <= '0;
      locked_o   <= 1'b0;
    end else begin
      ctl_wr_o <= 1'b0;
      cfg_wr_o <= 1'b0;
      locked_o <= (state_q == S_DONE);
      unique case (state_q)
        S_IDLE, S_DONE: if (kick_i) state_q <= S_INIT;
        S_CFG: if (fire_o) begin
          cfg_wr_o   <= 1'b1;
          cfg_data_o <= DW'(make_cfg(REFCNT, sel180_i));
          state_q    <= S_ON;
        end
        S_POLL: if (!gap_busy_i && ready_i) begin
          lock_q_o <= lock_i;
          state_q  <= S_FORCE;
        end
        default: if (fire_o) begin
          shadow_q   <= next_ctl;
          ctl_wr_o   <= 1'b1;
          ctl_data_o <= next_ctl;
          state_q    <= (state_q == S_INIT)  ? S_CFG  :
                        (state_q == S_ON)    ? S_GO   :
                        (state_q == S_GO)    ? S_POLL : S_DONE;
        end
      endcase
    end
  end

  // R2: the first write after a kick carries the fixed start value
  p_init_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_INIT && !gap_busy_i) |=> (ctl_wr_o && ctl_data_o == DW'(INIT_CTL)));
  // R5: strobes never overlap and never last two cycles
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_wr_o, cfg_wr_o}));
  p_strobe_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_o || cfg_wr_o) |=> !(ctl_wr_o || cfg_wr_o));
  // R6: polling holds while the ready bits are incomplete
  p_poll_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_POLL && !ready_i) |=> (state_q == S_POLL));
  // R8: locked rises only right after a control write
  p_locked_after_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(ctl_wr_o));
  // R9: a kick inside a running sequence never restarts it
  p_kick_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && state_q != S_IDLE && state_q != S_DONE) |=> (state_q != S_INIT));

endmodule

// File: rtl/dll_start_ctrl.sv
module dll_start_ctrl #(
  parameter int          DW        = 32,
  parameter int          SW        = 16,
  parameter int          RDY_W     = 3,
  parameter int          LOCK_LSB  = 6,
  parameter int          LOCK_W    = 8,
  parameter int          FORCE_LSB = 24,
  parameter int          GAP       = 1,
  parameter int          REFCNT    = 8,
  parameter logic [31:0] INIT_CTL  = 32'h0010_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick_i,
  input  logic          shift_sel_i,
  input  logic [SW-1:0] lock_stat_i,
  output logic          ctl_wr_o,
  output logic [DW-1:0] ctl_data_o,
  output logic          cfg_wr_o,
  output logic [DW-1:0] cfg_data_o,
  output logic          locked_o
);
  logic              gap_busy;
  logic              fire;
  logic              ready;
  logic [LOCK_W-1:0] lock_now;
  logic [LOCK_W-1:0] lock_held;
  logic [DW-1:0]     shadow;
  logic [DW-1:0]     merged;

  dll_gap_timer #(.GAP(GAP)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(fire),
    .busy_o(gap_busy)
  );

  dll_lock_merge #(
    .DW(DW), .SW(SW), .RDY_W(RDY_W), .LOCK_LSB(LOCK_LSB),
    .LOCK_W(LOCK_W), .FORCE_LSB(FORCE_LSB)
  ) u_merge (
    .stat_i  (lock_stat_i),
    .base_i  (shadow),
    .lock_i  (lock_held),
    .ready_o (ready),
    .lock_o  (lock_now),
    .merged_o(merged)
  );

  dll_seq_fsm #(
    .DW(DW), .LOCK_W(LOCK_W), .INIT_CTL(INIT_CTL), .REFCNT(REFCNT)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick_i    (kick_i),
    .sel180_i  (shift_sel_i),
    .gap_busy_i(gap_busy),
    .ready_i   (ready),
    .lock_i    (lock_now),
    .merged_i  (merged),
    .fire_o    (fire),
    .shadow_o  (shadow),
    .lock_q_o  (lock_held),
    .ctl_wr_o  (ctl_wr_o),
    .ctl_data_o(ctl_data_o),
    .cfg_wr_o  (cfg_wr_o),
    .cfg_data_o(cfg_data_o),
    .locked_o  (locked_o)
  );

  // R7: the write that sets locked carries the held lock value in its top field
  p_force_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> (ctl_data_o[FORCE_LSB +: LOCK_W] == lock_held));

endmodule

// File: tb/dll_start_ctrl_bench.sv
`timescale 1ns/1ps
module dll_start_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kick = 1'b0;
  logic        sel = 1'b0;
  logic [15:0] stat = '0;
  logic        ctl_wr, cfg_wr, locked;
  logic [31:0] ctl_data, cfg_data;

  int tests = 0, fails = 0, cyc = 0, wd = 0;
  int n_ev = 0;
  bit          ev_cfg [0:15];
  logic [31:0] ev_data[0:15];
  int          ev_cyc [0:15];
  bit          ev_lk  [0:15];

  always #2.5 clk = ~clk;

  dll_start_ctrl u_dll_start_ctrl (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .shift_sel_i(sel),
    .lock_stat_i(stat), .ctl_wr_o(ctl_wr), .ctl_data_o(ctl_data),
    .cfg_wr_o(cfg_wr), .cfg_data_o(cfg_data), .locked_o(locked)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    if ((ctl_wr || cfg_wr) && n_ev < 16) begin
      ev_cfg[n_ev]  = cfg_wr;
      ev_data[n_ev] = cfg_wr ? cfg_data : ctl_data;
      ev_cyc[n_ev]  = cyc;
      ev_lk[n_ev]   = locked;
      n_ev++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", wd);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [7:0] lv, input logic [2:0] rdy);
    return {~lv[1:0], lv, lv[4:2], rdy};
  endfunction

  task automatic run_seq(input logic sh, input logic [7:0] lv, input int pdel,
                         input bit early, input bit mid_kick);
    logic [2:0]  part[3] = '{3'b011, 3'b101, 3'b110};
    logic [31:0] base = 32'h0010_1000;
    int t;
    @(negedge clk);
    n_ev = 0;
    sel  = sh;
    stat = early ? mk(lv, 3'b111) : mk(~lv, 3'b011);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    for (int i = 0; i < 100 && n_ev < 4; i++) begin
      @(negedge clk);
      kick = mid_kick && (n_ev == 2);
    end
    kick = 1'b0;
    if (early) begin
      for (int i = 0; i < 20 && n_ev < 5; i++) @(negedge clk);
      chk("R11 force latency with early ready", 32'(ev_cyc[4] - ev_cyc[3]), 32'd3);
    end else begin
      for (int i = 0; i < pdel; i++) begin
        @(negedge clk);
        stat = mk(~lv, part[i % 3]);
      end
      chk("R6 no write while not ready", 32'(n_ev), 32'd4);
      @(negedge clk);
      stat = mk(lv, 3'b111);
      t = cyc;
      @(negedge clk);
      @(negedge clk);
      chk("R6 poll exit latency", 32'(ev_cyc[4]), 32'(t + 2));
      stat = mk(~lv, 3'b111);
    end
    chk("R2 first write kind", 32'(ev_cfg[0]), 32'd0);
    chk("R2 first write data", ev_data[0], base);
    chk("R3 config write kind", 32'(ev_cfg[1]), 32'd1);
    chk("R3 config write data", ev_data[1], 32'h80 | (sh ? 32'd6 : 32'd5));
    chk("R4 loop-on write", {31'd0, ev_cfg[2]} | ev_data[2], base | 32'd2);
    chk("R4 loop-start write", {31'd0, ev_cfg[3]} | ev_data[3], base | 32'd3);
    chk("R7 force write", {31'd0, ev_cfg[4]} ^ ev_data[4], base | 32'd3 | (32'(lv) << 24));
    for (int i = 0; i < 4; i++)
      chk("R5 write spacing", 32'(ev_cyc[i+1] - ev_cyc[i] >= 2), 32'd1);
    chk("R10 locked low at first write", 32'(ev_lk[0]), 32'd0);
    chk("R8 locked low during force write", 32'(ev_lk[4]), 32'd0);
    @(negedge clk);
    chk("R8 locked after force", 32'(locked), 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 locked holds", 32'(locked), 32'd1);
    chk("R9 exactly five writes", 32'(n_ev), 32'd5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ctl strobe", 32'(ctl_wr), 32'd0);
    chk("R1 reset cfg strobe", 32'(cfg_wr), 32'd0);
    chk("R1 reset locked", 32'(locked), 32'd0);
    rst_n = 1'b1;
    stat  = mk(8'hA5, 3'b111);
    repeat (6) @(negedge clk);
    chk("R1 no write without kick", 32'(n_ev), 32'd0);
    chk("R11 ready status alone does nothing", 32'(locked), 32'd0);
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 256; v++)
        run_seq(s[0], 8'(v), v % 5, (v % 7) == 3, (v % 11) == 4);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule